// File: doc/BRIEF.md
# Receive Buffer Allocation Filter

This block sits behind a serial bus receiver. When the receiver reports that a frame has been taken in completely, the block decides which of a small set of receive buffers should keep the frame. It compares the upper eleven identifier bits with one identifier per buffer, under a single shared acceptance mask. A mask bit of 0 turns the matching identifier bit into a don't-care. When more than one buffer matches, the lowest-numbered one wins. The block then issues a one-hot store enable to the buffer storage, which sits outside this block. It also reports a compact code for the chosen buffer.

For each buffer the block keeps a reception-OK flag and an overrun flag. Software clears them through a per-buffer clear strobe or a global clear strobe. A separate trigger comparator watches the same identifier bits against a trigger value. It raises a one-cycle pulse whenever they are equal, whatever the filter decides. Remote-request frames and frames that ended in error are never stored.

Top module: `rxbuf_alloc`

## Requirements
- R1: Buffer n matches when, for every identifier bit i from 28 down to 18, (rx_id[i] XOR buffer-n identifier bit) AND acc_mask bit equals 0. The buffer identifier of buffer n is buf_fid[n*11 +: 11] and the mask bit for rx_id[18+k] is acc_mask[k]. A mask bit of 0 makes that bit a don't-care.
- R2: Identifier bits 17 down to 0 never affect filtering. Two frames that differ only in those bits are routed identically.
- R3: At most one store_en bit is ever high. When several buffers match, only the lowest-numbered matching buffer gets store_en.
- R4: A frame with rx_rtr high is never stored. It sets buf_code to 00 and leaves every flag unchanged.
- R5: Nothing is stored unless frame_done is high. store_en goes high for exactly the one cycle after the clock edge that samples frame_done.
- R6: buf_code is updated one cycle after each error-free frame_done. It reads 00 when the frame is filtered out, and 01, 10 or 11 when the frame goes to buffer 1, 2 or 3 (store_en bit 0, 1 or 2). At all other times it holds its value.
- R7: A store into buffer n sets rx_ok[n]. If rx_ok[n] or rx_ovr[n] was already set, the same store also sets rx_ovr[n].
- R8: clr_buf[n] clears rx_ok[n] and rx_ovr[n]. If a store to buffer n happens in the same cycle, the clear acts first: rx_ok[n] ends at 1 and rx_ovr[n] ends at 0.
- R9: clr_all clears the OK and overrun flags of every buffer. It has the same same-cycle ordering as R8.
- R10: A frame_done with frame_err high causes no store, and leaves buf_code and all flags unchanged.
- R11: trig_pulse is high for the one cycle after any sampled frame_done whose rx_id[28:18] equals trig_fid. This holds regardless of mask, match, rx_rtr and frame_err.
- R12: While rst_n is low at a clock edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: end-of-frame field completed |
| frame_err | input | 1 | Qualifies frame_done: the frame ended with an error |
| rx_rtr | input | 1 | Qualifies frame_done: the frame is a remote request |
| rx_id | input | 29 | Received identifier (standard frames left-aligned at bit 28) |
| buf_fid | input | 33 | Packed buffer identifiers, buffer n at bits n*11 +: 11 |
| acc_mask | input | 11 | Shared acceptance mask, 1 = compare the bit |
| trig_fid | input | 11 | Trigger identifier compared with rx_id[28:18] |
| clr_buf | input | 3 | Per-buffer flag clear strobes |
| clr_all | input | 1 | Clear strobe for every buffer's flags |
| store_en | output | 3 | One-hot store enable to the buffer storage |
| buf_code | output | 2 | Buffer chosen by the last error-free frame, 0 = none |
| rx_ok | output | 3 | Per-buffer reception-OK flags |
| rx_ovr | output | 3 | Per-buffer overrun flags |
| trig_pulse | output | 1 | One-cycle trigger match pulse |

## Verification
The embedded properties assume that frame_done, frame_err and rx_rtr are sampled together, and that the qualifiers have meaning only in the cycle where frame_done is high. They also assume that the clear strobes may coincide with a frame. Nothing is assumed about the stability of the identifiers or the mask. The stimulus changes every input on the falling edge and drives frame_done as a single-cycle strobe with idle gaps. It mixes remote and errored frames and changes the mask between frames. Clear strobes land at random, including in the same cycle as a store, so the ordering rules of R8 and R9 are reached.

// File: rtl/rxa_pkg.sv
// Package rxa_pkg
// Purpose : default geometry shared by the receive buffer allocation filter.
// Assumes : identifier numbering with bit 28 as the most significant bit.
package rxa_pkg;
    localparam int unsigned RXA_NUM_BUF = 3;
    localparam int unsigned RXA_ID_W    = 29;
    localparam int unsigned RXA_FILT_HI = 28;
    localparam int unsigned RXA_FILT_LO = 18;
endpackage

// File: rtl/rxa_match.sv
// Module  : rxa_match
// Purpose : masked identity comparison of one filter field against every
//           buffer identifier in parallel.
// Assumes : buf_fid packs buffer n at bits n*FILT_W +: FILT_W; mask bit 1
//           means "compare", 0 means "don't care". Purely combinational.
module rxa_match #(
    parameter int unsigned NUM_BUF = 3,
    parameter int unsigned FILT_W  = 11
) (
    input  logic [FILT_W-1:0]         rx_fid,
    input  logic [NUM_BUF*FILT_W-1:0] buf_fid,
    input  logic [FILT_W-1:0]         mask,
    output logic [NUM_BUF-1:0]        hit
);
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_cmp
        logic [FILT_W-1:0] diff;
        // bits that differ and are not masked out
        assign diff   = (rx_fid ^ buf_fid[b*FILT_W +: FILT_W]) & mask;
        assign hit[b] = (diff == '0);
    end
endmodule

// File: rtl/rxa_prio.sv
// Module  : rxa_prio
// Purpose : picks the lowest-numbered asserted hit, returns it one-hot and
//           as a code (index + 1, 0 when no hit).
// Assumes : CODE_W is wide enough for NUM_BUF + 1 values. Combinational.
module rxa_prio #(
    parameter int unsigned NUM_BUF = 3,
    parameter int unsigned CODE_W  = 2
) (
    input  logic [NUM_BUF-1:0] hit,
    output logic [NUM_BUF-1:0] pick,
    output logic [CODE_W-1:0]  code
);
    // scan from the top so the lowest index is written last and wins
    always_comb begin
        pick = '0;
        code = '0;
        for (int b = NUM_BUF - 1; b >= 0; b--) begin
            if (hit[b]) begin
                pick    = '0;
                pick[b] = 1'b1;
                code    = CODE_W'(b + 1);
            end
        end
    end
endmodule

// File: rtl/rxa_flags.sv
// Module  : rxa_flags
// Purpose : per-buffer reception-OK and overrun flags.
// Assumes : store_sel is one-hot or zero and already qualified; a clear in
//           the same cycle as a store is applied before the store.
module rxa_flags #(
    parameter int unsigned NUM_BUF = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] store_sel,
    input  logic [NUM_BUF-1:0] clr_buf,
    input  logic               clr_all,
    output logic [NUM_BUF-1:0] ok_q,
    output logic [NUM_BUF-1:0] ovr_q
);
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        logic wipe;
        logic ok_r;
        logic ovr_r;

        assign wipe = clr_all | clr_buf[b];

        // flag update: store wins over clear, clear acts on the old value
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ok_r  <= 1'b0;
                ovr_r <= 1'b0;
            end else if (store_sel[b]) begin
                ok_r  <= 1'b1;
                ovr_r <= ~wipe & (ok_r | ovr_r);
            end else if (wipe) begin
                ok_r  <= 1'b0;
                ovr_r <= 1'b0;
            end
        end

        assign ok_q[b]  = ok_r;
        assign ovr_q[b] = ovr_r;

        // R7: an overrun never stands without the OK flag
        p_ovr_with_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ovr_r |-> ok_r);
        // R7: a store always leaves the OK flag set
        p_store_sets_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
            store_sel[b] |=> ok_r);
        // R8: a clear without a store empties both flags
        p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wipe && !store_sel[b]) |=> (!ok_r && !ovr_r));
        // R8: a clear together with a store leaves no overrun
        p_clear_then_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wipe && store_sel[b]) |=> (ok_r && !ovr_r));
    end
endmodule

// File: rtl/rxa_trig.sv
// Module  : rxa_trig
// Purpose : one-cycle pulse when a completed frame carries the trigger id.
// Assumes : frame_done is a single-cycle strobe; filter outcome ignored.
module rxa_trig #(
    parameter int unsigned FILT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [FILT_W-1:0] rx_fid,
    input  logic [FILT_W-1:0] trig_fid,
    output logic              trig_q
);
    // register the equality result for exactly one cycle per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= frame_done && (rx_fid == trig_fid);
    end

    // R11: a pulse only follows a sampled end-of-frame strobe
    p_trig_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> $past(frame_done));
endmodule

// File: rtl/rxbuf_alloc.sv
// Module  : rxbuf_alloc
// Purpose : top of the receive buffer allocation filter. Routes a completed,
//           error-free data frame to the lowest-numbered matching buffer,
//           keeps per-buffer flags and drives the trigger pulse.
// Assumes : frame_done is a one-cycle strobe qualified by frame_err and
//           rx_rtr in the same cycle; reset is synchronous, active low.
module rxbuf_alloc
    import rxa_pkg::*;
#(
    parameter int unsigned NUM_BUF = RXA_NUM_BUF,
    parameter int unsigned ID_W    = RXA_ID_W,
    parameter int unsigned FILT_HI = RXA_FILT_HI,
    parameter int unsigned FILT_LO = RXA_FILT_LO,
    localparam int unsigned FILT_W = FILT_HI - FILT_LO + 1,
    localparam int unsigned CODE_W = $clog2(NUM_BUF + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_done,
    input  logic                      frame_err,
    input  logic                      rx_rtr,
    input  logic [ID_W-1:0]           rx_id,
    input  logic [NUM_BUF*FILT_W-1:0] buf_fid,
    input  logic [FILT_W-1:0]         acc_mask,
    input  logic [FILT_W-1:0]         trig_fid,
    input  logic [NUM_BUF-1:0]        clr_buf,
    input  logic                      clr_all,
    output logic [NUM_BUF-1:0]        store_en,
    output logic [CODE_W-1:0]         buf_code,
    output logic [NUM_BUF-1:0]        rx_ok,
    output logic [NUM_BUF-1:0]        rx_ovr,
    output logic                      trig_pulse
);
    logic [FILT_W-1:0]  rx_fid;
    logic [NUM_BUF-1:0] hit;
    logic [NUM_BUF-1:0] pick;
    logic [CODE_W-1:0]  pick_code;
    logic               good_frame;
    logic               accept;
    logic [NUM_BUF-1:0] store_sel;
    logic               unused_low_id;

    assign rx_fid        = rx_id[FILT_HI:FILT_LO];
    assign unused_low_id = ^rx_id[FILT_LO-1:0];

    assign good_frame = frame_done & ~frame_err;
    assign accept     = good_frame & ~rx_rtr;
    assign store_sel  = accept ? pick : '0;

    rxa_match #(.NUM_BUF(NUM_BUF), .FILT_W(FILT_W)) i_match (
        .rx_fid  (rx_fid),
        .buf_fid (buf_fid),
        .mask    (acc_mask),
        .hit     (hit)
    );

    rxa_prio #(.NUM_BUF(NUM_BUF), .CODE_W(CODE_W)) i_prio (
        .hit  (hit),
        .pick (pick),
        .code (pick_code)
    );

    rxa_flags #(.NUM_BUF(NUM_BUF)) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_sel (store_sel),
        .clr_buf   (clr_buf),
        .clr_all   (clr_all),
        .ok_q      (rx_ok),
        .ovr_q     (rx_ovr)
    );

    rxa_trig #(.FILT_W(FILT_W)) i_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .rx_fid     (rx_fid),
        .trig_fid   (trig_fid),
        .trig_q     (trig_pulse)
    );

    // store enable: one-cycle registered copy of the qualified selection
    always_ff @(posedge clk) begin
        if (!rst_n) store_en <= '0;
        else        store_en <= store_sel;
    end

    // buffer code: refreshed on every error-free frame, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)          buf_code <= '0;
        else if (good_frame) buf_code <= rx_rtr ? '0 : pick_code;
    end

    // R3: never more than one buffer written
    p_onehot_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(store_en));
    // R4: a remote request is never stored
    p_no_store_remote_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_rtr) |=> (store_en == '0));
    // R5: a store is always the echo of an error-free strobe
    p_store_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en != '0) |-> $past(frame_done && !frame_err));
    // R6: a stored frame always reports a non-zero code
    p_code_on_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en != '0) |-> (buf_code != '0));
    // R10: an errored frame changes nothing when no clear is pending
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_err && !clr_all && (clr_buf == '0)) |=>
        ((store_en == '0) && $stable(buf_code) && $stable(rx_ok) && $stable(rx_ovr)));
endmodule

// File: tb/test_rxbuf_alloc.sv
module test_rxbuf_alloc;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_done, frame_err, rx_rtr;
    logic [28:0] rx_id;
    logic [32:0] buf_fid;
    logic [10:0] acc_mask, trig_fid;
    logic [2:0]  clr_buf;
    logic        clr_all;
    logic [2:0]  store_en, rx_ok, rx_ovr;
    logic [1:0]  buf_code;
    logic        trig_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    logic [2:0] m_store, m_ok, m_ovr;
    logic [1:0] m_code;
    logic       m_trig;

    always #4 clk = ~clk;

    rxbuf_alloc i_rxbuf_alloc (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_err(frame_err),
        .rx_rtr(rx_rtr), .rx_id(rx_id), .buf_fid(buf_fid), .acc_mask(acc_mask),
        .trig_fid(trig_fid), .clr_buf(clr_buf), .clr_all(clr_all),
        .store_en(store_en), .buf_code(buf_code), .rx_ok(rx_ok), .rx_ovr(rx_ovr),
        .trig_pulse(trig_pulse)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural model: evaluated on each rising edge from the requirements
    always @(posedge clk) begin : model
        logic [2:0] nok, novr, st;
        int win;
        if (!rst_n) begin
            m_store = '0; m_ok = '0; m_ovr = '0; m_code = '0; m_trig = 1'b0;
        end else begin
            nok = m_ok; novr = m_ovr; st = '0;
            for (int b = 0; b < 3; b++)
                if (clr_all || clr_buf[b]) begin nok[b] = 1'b0; novr[b] = 1'b0; end
            m_trig = frame_done && (rx_id[28:18] == trig_fid);
            if (frame_done && !frame_err) begin
                win = -1;
                if (!rx_rtr)
                    for (int b = 0; b < 3; b++)
                        if (win < 0 && (((rx_id[28:18] ^ buf_fid[b*11 +: 11]) & acc_mask) == 11'h0))
                            win = b;
                m_code = (win < 0) ? 2'd0 : 2'(win + 1);
                if (win >= 0) begin
                    st[win] = 1'b1;
                    if (nok[win]) novr[win] = 1'b1;
                    nok[win] = 1'b1;
                end
            end
            m_store = st; m_ok = nok; m_ovr = novr;
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (!done && rst_n !== 1'bx) begin
            chk(32'(store_en),   32'(m_store), "R3",  "store_en");
            chk(32'(buf_code),   32'(m_code),  "R6",  "buf_code");
            chk(32'(rx_ok),      32'(m_ok),    "R7",  "rx_ok");
            chk(32'(rx_ovr),     32'(m_ovr),   "R7",  "rx_ovr");
            chk(32'(trig_pulse), 32'(m_trig),  "R11", "trig_pulse");
        end
    end

    task automatic frame(input logic [10:0] hi, input logic [17:0] lo,
                         input bit rtr, input bit err, input logic [2:0] cb = 3'b000);
        @(negedge clk);
        frame_done = 1'b1; rx_id = {hi, lo}; rx_rtr = rtr; frame_err = err; clr_buf = cb;
        @(negedge clk);
        frame_done = 1'b0; rx_rtr = 1'b0; frame_err = 1'b0; clr_buf = '0;
    endtask

    task automatic clear(input logic [2:0] cb, input bit all);
        @(negedge clk);
        clr_buf = cb; clr_all = all;
        @(negedge clk);
        clr_buf = '0; clr_all = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_done = 0; frame_err = 0; rx_rtr = 0; rx_id = '0;
        buf_fid = {11'h7FF, 11'h120, 11'h123};
        acc_mask = 11'h7FF; trig_fid = 11'h555; clr_buf = '0; clr_all = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(32'({store_en, buf_code, rx_ok, rx_ovr, trig_pulse}), 0, "R12", "outputs in reset");
        rst_n = 1'b1;

        frame(11'h123, 18'h0, 0, 0);
        chk(32'(store_en), 32'b001, "R1", "exact match store");
        chk(32'(buf_code), 1, "R6", "code buffer 1");
        chk(32'(rx_ok), 32'b001, "R7", "ok after store");

        frame(11'h123, 18'h3FFFF, 0, 0);
        chk(32'(store_en), 32'b001, "R2", "low bits ignored");
        chk(32'(rx_ovr), 32'b001, "R7", "overrun set");

        clear(3'b001, 0);
        chk(32'({rx_ok, rx_ovr}), 0, "R8", "per-buffer clear");

        acc_mask = 11'h7F0;
        frame(11'h12F, 18'h15, 0, 0);
        chk(32'(store_en), 32'b001, "R3", "lowest of two matches");
        buf_fid[10:0] = 11'h400;
        frame(11'h12F, 18'h0, 0, 0);
        chk(32'(store_en), 32'b010, "R1", "masked match buffer 2");
        chk(32'(buf_code), 2, "R6", "code buffer 2");
        buf_fid[10:0] = 11'h123;
        acc_mask = 11'h7FF;

        frame(11'h7FF, 18'h0, 1, 0);
        chk(32'(store_en), 0, "R4", "remote not stored");
        chk(32'(buf_code), 0, "R4", "remote code");
        chk(32'(rx_ok), 32'b011, "R4", "remote flags untouched");

        frame(11'h7FF, 18'h0, 0, 0);
        chk(32'(buf_code), 3, "R6", "code buffer 3");
        frame(11'h123, 18'h0, 0, 1);
        chk(32'(store_en), 0, "R10", "errored frame no store");
        chk(32'(buf_code), 3, "R10", "errored frame code held");
        chk(32'({rx_ok, rx_ovr}), 32'b111000, "R10", "errored frame flags");

        @(negedge clk); rx_id = {11'h123, 18'h0};
        @(negedge clk);
        chk(32'(store_en), 0, "R5", "no strobe no store");

        frame(11'h123, 18'h0, 0, 0);
        chk(32'(rx_ovr), 32'b001, "R7", "overrun before global clear");
        clear(3'b000, 1);
        chk(32'({rx_ok, rx_ovr}), 0, "R9", "global clear");

        frame(11'h555, 18'h0, 0, 1);
        chk(32'(trig_pulse), 1, "R11", "trigger on errored frame");
        @(negedge clk);
        chk(32'(trig_pulse), 0, "R11", "trigger one cycle");
        frame(11'h555, 18'h0, 0, 0);
        chk(32'(trig_pulse), 1, "R11", "trigger on filtered-out frame");
        chk(32'(buf_code), 0, "R6", "filtered out code");

        frame(11'h123, 18'h0, 0, 0);
        frame(11'h123, 18'h0, 0, 0, 3'b001);
        chk(32'({rx_ok[0], rx_ovr[0]}), 32'b10, "R8", "clear and store same cycle");

        for (int n = 0; n < 400; n++) begin
            logic [10:0] hi;
            case ($urandom_range(0, 4))
                0: hi = 11'h123;
                1: hi = 11'h120;
                2: hi = 11'h7FF;
                3: hi = 11'h555;
                default: hi = 11'($urandom);
            endcase
            case ($urandom_range(0, 3))
                0: acc_mask = 11'h7FF;
                1: acc_mask = 11'h7F0;
                2: acc_mask = 11'h000;
                default: acc_mask = 11'($urandom);
            endcase
            clr_all = ($urandom_range(0, 9) == 0);
            frame(hi, 18'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                  ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000);
            clr_all = 1'b0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule